// File: doc/BRIEF.md
# Two-Stage Boot Lock Sequencer

This block keeps a cartridge mapper locked through two boot phases before it opens up. After reset the mapper sits in a monochrome-boot lock. It leaves that lock either by counting a fixed number of address-line events or at once, when anything touches cartridge RAM space. It then enters a colour-boot lock. During the colour-boot lock the block asserts a logo-switch output, which the surrounding mapper uses to force ROM address bit 7 high. After a second full count the block reaches the unlocked mode and stays there until reset.

A counted event is a ROM read strobe with the A15 line high, where the A15 value sampled at the previous ROM read was low. Only ROM read strobes sample A15. Reset treats the previous sample as high, so the first read that drives A15 low only arms the detector. The counter stops climbing once it reaches its target value (0x30 by default). The next counted event after that point advances the mode. Cartridge RAM space is not populated: reads return all ones and writes are dropped.

Top module: `boot_lock_seq`

## Requirements
- R1: After reset, mode_o is 0 (monochrome lock), logo_force_o is 0, and the event counter is 0.
- R2: An event is counted only when rom_rd_i is high, a15_i is high, and a15_i was low at the previous rom_rd_i strobe. After reset the previous sample is taken as high, so reads with a15_i held high count nothing.
- R3: In mode 0, counted events raise the counter, which stops at TARGET (0x30). The next counted event after that moves mode_o to 1 (colour lock) and clears the counter. From reset, 48 events leave mode_o at 0 and the 49th sets it to 1.
- R4: In mode 1 the counter again climbs from 0 and stops at TARGET. The next counted event moves mode_o to 2 (unlocked). So 48 events in mode 1 leave mode_o at 1 and the 49th sets it to 2.
- R5: mode_o never goes from 0 straight to 2, and never returns from a higher mode to a lower one except through reset.
- R6: logo_force_o is 1 exactly while mode_o is 1.
- R7: A ram_acc_i strobe in mode 0 sets mode_o to 1 on the next clock edge and clears the counter.
- R8: A ram_acc_i strobe in mode 1 changes neither the mode nor the counter.
- R9: If ram_acc_i and a counted event occur in the same cycle in mode 0, the RAM transition wins. The event is not counted, and mode 1 then needs a full 49 events to unlock.
- R10: Mode 2 is terminal. Further events and RAM strobes leave it at 2 until reset.
- R11: ram_rdata_o is 0xFF at all times.
- R12: Without a rom_rd_i or ram_acc_i strobe, mode_o holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a15_i | input | 1 | Address line A15 from the bus |
| rom_rd_i | input | 1 | One-cycle ROM read strobe |
| ram_acc_i | input | 1 | One-cycle cartridge RAM read or write strobe |
| mode_o | output | 2 | Lock mode: 0 monochrome lock, 1 colour lock, 2 unlocked |
| logo_force_o | output | 1 | Force ROM address bit 7 high |
| ram_rdata_o | output | 8 | Cartridge RAM read data (always 0xFF) |

## Verification
Two things can land in the same clock in the monochrome lock: a RAM strobe that skips the first stage, and a counted A15 event. The bench sets up this collision after a run of events. It drives a low read, then a high read with ram_acc_i raised in the same cycle. It then judges the result by counting how many further events it takes to unlock: exactly 49 if the RAM clear won, and fewer if the event leaked into the counter.

// File: rtl/boot_lock_pkg.sv
package boot_lock_pkg;
  typedef enum logic [1:0] {
    LK_MONO   = 2'd0,
    LK_COLOUR = 2'd1,
    LK_OPEN   = 2'd2
  } lock_mode_e;
endpackage

// File: rtl/a15_rise_det.sv
// Detects a rising A15 between two successive ROM read strobes.
module a15_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_stb,
  input  logic a15,
  output logic rise_evt
);
  logic last_a15_q;

  // Bootstrap runs with A15 high, so reset assumes a high sample.
  always_ff @(posedge clk) begin
    if (!rst_n)      last_a15_q <= 1'b1;
    else if (rd_stb) last_a15_q <= a15;
  end

  assign rise_evt = rd_stb & a15 & ~last_a15_q;
endmodule

// File: rtl/lock_counter.sv
// Saturating event counter with a synchronous clear that has priority.
module lock_counter #(
  parameter int CNT_W  = 8,
  parameter int TARGET = 8'h30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt,
  output logic             at_target
);
  localparam logic [CNT_W-1:0] TGT = CNT_W'(TARGET);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  assign at_target = (cnt == TGT);

  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (clr)               cnt <= '0;
    else if (evt && !at_target) cnt <= cnt + ONE;
  end
endmodule

// File: rtl/lock_fsm.sv
// Three-mode lock state machine.
module lock_fsm
  import boot_lock_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt,
  input  logic       at_target,
  input  logic       ram_acc,
  output lock_mode_e mode,
  output logic       clr_cnt
);
  lock_mode_e mode_d;

  always_comb begin
    mode_d  = mode;
    clr_cnt = 1'b0;
    unique case (mode)
      LK_MONO: begin
        // A RAM access outranks a same-cycle counter event.
        if (ram_acc || (evt && at_target)) begin
          mode_d  = LK_COLOUR;
          clr_cnt = 1'b1;
        end
      end
      LK_COLOUR: begin
        if (evt && at_target) mode_d = LK_OPEN;
      end
      default: mode_d = LK_OPEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) mode <= LK_MONO;
    else        mode <= mode_d;
  end
endmodule

// File: rtl/boot_lock_seq.sv
module boot_lock_seq
  import boot_lock_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int TARGET = 8'h30,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              a15_i,
  input  logic              rom_rd_i,
  input  logic              ram_acc_i,
  output logic [1:0]        mode_o,
  output logic              logo_force_o,
  output logic [DATA_W-1:0] ram_rdata_o
);
  logic             rise_evt;
  logic             clr_cnt;
  logic             at_target;
  logic [CNT_W-1:0] cnt;
  lock_mode_e       mode;

  a15_rise_det u_det (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb   (rom_rd_i),
    .a15      (a15_i),
    .rise_evt (rise_evt)
  );

  lock_counter #(.CNT_W(CNT_W), .TARGET(TARGET)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (rise_evt),
    .clr       (clr_cnt),
    .cnt       (cnt),
    .at_target (at_target)
  );

  lock_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt       (rise_evt),
    .at_target (at_target),
    .ram_acc   (ram_acc_i),
    .mode      (mode),
    .clr_cnt   (clr_cnt)
  );

  assign mode_o       = mode;
  assign logo_force_o = (mode == LK_COLOUR);
  assign ram_rdata_o  = '1;
endmodule

// File: rtl/boot_lock_seq_chk.sv
module boot_lock_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rom_rd_i,
  input logic       ram_acc_i,
  input logic [1:0] mode_o,
  input logic       logo_force_o
);
  a_r7_ram_skip: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0 && ram_acc_i) |=> (mode_o == 2'd1));

  a_r10_terminal: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd2) |=> (mode_o == 2'd2));

  a_r5_no_jump: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd0) |=> (mode_o != 2'd2));

  a_r5_no_return: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o == 2'd1) |=> (mode_o != 2'd0));

  a_r6_logo_off: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_o != 2'd1) |-> !logo_force_o);

  a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!rom_rd_i && !ram_acc_i) |=> $stable(mode_o));
endmodule

bind boot_lock_seq boot_lock_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rom_rd_i     (rom_rd_i),
  .ram_acc_i    (ram_acc_i),
  .mode_o       (mode_o),
  .logo_force_o (logo_force_o)
);

// File: tb/boot_lock_seq_tb_top.sv
module boot_lock_seq_tb_top;
  localparam time CLK_P = 20ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       a15_i = 1'b1;
  logic       rom_rd_i = 1'b0;
  logic       ram_acc_i = 1'b0;
  logic [1:0] mode_o;
  logic       logo_force_o;
  logic [7:0] ram_rdata_o;

  int n_chk = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  boot_lock_seq dut_i (
    .clk(clk), .rst_n(rst_n), .a15_i(a15_i), .rom_rd_i(rom_rd_i),
    .ram_acc_i(ram_acc_i), .mode_o(mode_o), .logo_force_o(logo_force_o),
    .ram_rdata_o(ram_rdata_o)
  );

  // Row: {req[3:0], kind[1:0], reps[7:0], exp_mode[1:0]}
  // kind 0 = counted events (low read then high read), 1 = RAM strobe,
  // 2 = reset, 3 = reads with A15 held high
  localparam int NV = 13;
  localparam logic [15:0] VECS [NV] = '{
    {4'd1,  2'd2, 8'd0,  2'd0},  // R1 reset state
    {4'd2,  2'd3, 8'd5,  2'd0},  // R2 steady-high reads count nothing
    {4'd3,  2'd0, 8'd48, 2'd0},  // R3 48 events stay locked
    {4'd3,  2'd0, 8'd1,  2'd1},  // R3 49th event -> colour lock
    {4'd4,  2'd0, 8'd48, 2'd1},  // R4 counter restarted
    {4'd8,  2'd1, 8'd1,  2'd1},  // R8 RAM strobe ignored in colour
    {4'd4,  2'd0, 8'd1,  2'd2},  // R4 unlock
    {4'd10, 2'd1, 8'd1,  2'd2},  // R10 RAM strobe when unlocked
    {4'd10, 2'd0, 8'd60, 2'd2},  // R10 more events when unlocked
    {4'd1,  2'd2, 8'd0,  2'd0},  // R1 reset back to mono lock
    {4'd7,  2'd1, 8'd1,  2'd1},  // R7 RAM skips stage one
    {4'd7,  2'd0, 8'd48, 2'd1},  // R7 counter was cleared
    {4'd7,  2'd0, 8'd1,  2'd2}   // R7 full second stage then unlock
  };

  task automatic check(input int req, input logic [1:0] exp_mode);
    logic exp_logo;
    exp_logo = (exp_mode == 2'd1);
    n_chk++;
    if (mode_o !== exp_mode || logo_force_o !== exp_logo || ram_rdata_o !== 8'hFF) begin
      n_fail++;
      $display("FAIL R%0d: mode=%0d logo=%0b rdata=%h expected mode=%0d logo=%0b rdata=ff",
               req, mode_o, logo_force_o, ram_rdata_o, exp_mode, exp_logo);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; rom_rd_i = 1'b0; ram_acc_i = 1'b0; a15_i = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic rd(input logic a);
    @(negedge clk);
    rom_rd_i = 1'b1; a15_i = a;
    @(negedge clk);
    rom_rd_i = 1'b0;
  endtask

  task automatic events(input int n);
    for (int i = 0; i < n; i++) begin
      rd(1'b0);
      rd(1'b1);
    end
  endtask

  task automatic ram_stb();
    @(negedge clk);
    ram_acc_i = 1'b1;
    @(negedge clk);
    ram_acc_i = 1'b0;
  endtask

  initial begin
    #(CLK_P * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not end, got hang expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      logic [15:0] row;
      row = VECS[v];
      case (row[11:10])
        2'd0: events(int'(row[9:2]));
        2'd1: ram_stb();
        2'd2: do_reset();
        default: for (int k = 0; k < int'(row[9:2]); k++) rd(1'b1);
      endcase
      @(negedge clk);
      check(int'(row[15:12]), row[1:0]);
    end

    // R9: RAM strobe and counted event in the same cycle in mono lock
    do_reset();
    events(10);
    rd(1'b0);
    @(negedge clk);
    rom_rd_i = 1'b1; a15_i = 1'b1; ram_acc_i = 1'b1;
    @(negedge clk);
    rom_rd_i = 1'b0; ram_acc_i = 1'b0;
    check(9, 2'd1);        // R9 moved to colour lock
    events(48);
    @(negedge clk);
    check(9, 2'd1);        // R9 the colliding event was not counted
    events(1);
    @(negedge clk);
    check(9, 2'd2);        // R9 unlock at the 49th event

    // R2: a first low read after reset only arms the detector
    do_reset();
    rd(1'b0);
    events(47);
    rd(1'b0);
    rd(1'b1);              // 48th counted event
    @(negedge clk);
    check(2, 2'd0);        // R2 still locked
    events(1);
    @(negedge clk);
    check(2, 2'd1);        // R2 49th event advances

    // R12: idle cycles hold the colour lock; R6 logo stays high
    repeat (20) @(negedge clk);
    check(12, 2'd1);
    check(6, 2'd1);

    // R11: RAM data stays all ones during and after a RAM access
    @(negedge clk);
    ram_acc_i = 1'b1;
    #1;
    check(11, 2'd1);
    @(negedge clk);
    ram_acc_i = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule